// File: doc/BRIEF.md
# Serial Control Port with Sticky Line-Change Interrupt

This block is the configuration and status port of a four-line transmission device. A host frames each transfer by pulling a select line low and clocking 16 bits in over a serial data pin. The first byte carries a read/write flag and a register address. The second byte is write data, or on a read it is the byte the device sends back on the serial output. Three byte-wide control registers can be written and read back. A read-only status register at address 0 shows, for each line, a line-status bit and a bipolar-violation bit.

The serial clock has no fixed phase relation to the core clock. All serial pins therefore pass through two-flop synchronisers, and the serial clock edges are detected in the core domain. The core clock must run well above the serial clock, at least four core cycles per serial half period. A separate latch drives an active-low interrupt. The latch sets when any line-status bit changes and stays set until the host reads the status register. Violation bits never set the latch.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, irq_n is 1, sdo_oe is 0, sdo is 0 and all three control registers read back as 0x00.
- R2: While sel_n is high, serial clock edges shift nothing and change no register, and sdo_oe is 0.
- R3: sdi is sampled on rising sclk edges, MSB first. In the first byte, bit 7 = 1 means read and bit 7 = 0 means write, and bits 1:0 are the address. Address 0 is status and addresses 1 to 3 are the control registers.
- R4: On a write to address 1, 2 or 3, the second byte is stored into that register at the 16th rising edge. A later read returns it.
- R5: On a read, the addressed byte is captured at the 8th rising edge. It appears on sdo MSB first, one bit per falling sclk edge, starting at the falling edge after that capture. sdo_oe stays 1 from the capture until sel_n returns high.
- R6: The status byte has bits 7:4 = violation bits of lines 3..0 and bits 3:0 = line-status bits of lines 3..0.
- R7: A write to address 0 changes no register.
- R8: Any change of a line-status bit pulls irq_n low on the third rising core clock edge after the change is presented. irq_n then stays low.
- R9: Changes of violation bits never pull irq_n low.
- R10: A read of address 0 releases irq_n at the third core edge after the 8th rising sclk edge. A read of a control register leaves irq_n unchanged.
- R11: If a line-status change sets the latch in the same core cycle as a status read clears it, the latch stays set.
- R12: Rising sclk edges after the 16th are ignored. A transfer abandoned by raising sel_n before the 16th rising edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial control clock, asynchronous to clk |
| sel_n | input | 1 | Active-low transfer select |
| sdi | input | 1 | Serial data in |
| line_stat | input | 4 | Per-line status bits from the line core |
| line_bpv | input | 4 | Per-line bipolar-violation bits |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets three collisions.

- A line change that lands in the same core cycle as the clearing status read. A design giving the clear priority would drop that event and release irq_n.
- A violation bit that toggles on its own. A design that fed it into the change detector would raise a false interrupt.
- Frames that run past 16 edges, frames cut short, and edges sent with select high. A counter that wraps or keeps running would commit a wrong or partial byte into a control register, and a later read-back would show that byte.

Readback order is checked bit by bit. A load one edge early or late would shift the returned byte by one position.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int N_LINES    = 4;
  localparam int ADDR_W     = 2;
  localparam int N_CTRL     = 3;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  // status byte: violation bits in the upper half, line bits in the lower half
  function automatic byte_t pack_status(input logic [N_LINES-1:0] bpv,
                                        input logic [N_LINES-1:0] lst);
    return byte_t'({bpv, lst});
  endfunction

  // bit counter that stops at the end of the frame
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c < CNT_W'(FRAME_BITS)) ? c + 1'b1 : c;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ctl_serial_engine.sv
module ctl_serial_engine
  import ctl_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  byte_t             rd_byte,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              ld_pulse,
  output logic              commit_pulse,
  output byte_t             wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              sclk_d;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shift_in;
  logic              instr_rd;
  logic [ADDR_W-1:0] instr_addr;
  logic              rd_phase;
  byte_t             out_sr;
  logic              sdo_q;

  // named edge events
  logic  rise, fall, active, at_instr, at_last;
  byte_t next_byte;

  assign active    = ~sel_s;
  assign rise      = active & sclk_s & ~sclk_d;
  assign fall      = active & ~sclk_s & sclk_d;
  assign next_byte = {shift_in, sdi_s};
  assign at_instr  = rise & (cnt == CNT_W'(BYTE_W - 1));
  assign at_last   = rise & (cnt == CNT_W'(FRAME_BITS - 1));

  assign ld_pulse     = at_instr & next_byte[BYTE_W-1];
  assign commit_pulse = at_last & ~instr_rd;
  assign reg_addr     = at_instr ? next_byte[ADDR_W-1:0] : instr_addr;
  assign wr_data      = next_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cnt        <= '0;
      shift_in   <= '0;
      instr_rd   <= 1'b0;
      instr_addr <= '0;
      rd_phase   <= 1'b0;
      out_sr     <= '0;
      sdo_q      <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (sel_s) begin
        cnt      <= '0;
        rd_phase <= 1'b0;
        sdo_q    <= 1'b0;
      end else begin
        if (rise && cnt < CNT_W'(FRAME_BITS)) begin
          cnt      <= cnt_step(cnt);
          shift_in <= next_byte[BYTE_W-2:0];
        end
        if (at_instr) begin
          instr_rd   <= next_byte[BYTE_W-1];
          instr_addr <= next_byte[ADDR_W-1:0];
        end
        if (ld_pulse) begin
          out_sr   <= rd_byte;
          rd_phase <= 1'b1;
        end else if (fall && rd_phase) begin
          sdo_q  <= out_sr[BYTE_W-1];
          out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = rd_phase & active;

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
  // R2
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (cnt == '0) && !sdo_oe);
  // R5
  load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |=> (cnt == CNT_W'(BYTE_W)) && rd_phase);
  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_pulse, commit_pulse}));
endmodule

// File: rtl/ctl_irq_latch.sv
module ctl_irq_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lst_s,
  input  logic         clr,
  output logic         irq_q,
  output logic         chg
);
  logic [N-1:0] prev;

  assign chg = |(lst_s ^ prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      irq_q <= 1'b0;
    end else begin
      prev <= lst_s;
      if (chg)      irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  // R8
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> irq_q);
  // R11
  set_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && clr) |=> irq_q);
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chg) |=> !irq_q);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !clr) |=> $stable(irq_q));
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sel_n,
  input  logic               sdi,
  input  logic [N_LINES-1:0] line_stat,
  input  logic [N_LINES-1:0] line_bpv,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               irq_n
);
  logic              sel_s, sclk_s, sdi_s;
  logic [N_LINES-1:0] lst_s, bpv_s;
  logic [ADDR_W-1:0] reg_addr;
  logic              ld_pulse, commit_pulse, clr_evt, irq_q, chg_evt;
  byte_t             wr_data, rd_byte;
  logic [N_CTRL-1:0][BYTE_W-1:0] ctrl_q;

  ctl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sel_n, sclk, sdi}), .q({sel_s, sclk_s, sdi_s}));

  ctl_sync #(.W(2 * N_LINES), .STAGES(2), .RST_VAL('0)) u_line_sync (
    .clk(clk), .rst_n(rst_n),
    .d({line_bpv, line_stat}), .q({bpv_s, lst_s}));

  ctl_serial_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_byte(rd_byte), .reg_addr(reg_addr), .ld_pulse(ld_pulse),
    .commit_pulse(commit_pulse), .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe));

  // control registers live at addresses 1..N_CTRL
  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[g] <= '0;
      else if (commit_pulse && reg_addr == ADDR_W'(g + 1))
        ctrl_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = pack_status(bpv_s, lst_s);
    for (int i = 0; i < N_CTRL; i++)
      if (reg_addr == ADDR_W'(i + 1)) rd_byte = ctrl_q[i];
  end

  assign clr_evt = ld_pulse && (reg_addr == '0);

  ctl_irq_latch #(.N(N_LINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .lst_s(lst_s), .clr(clr_evt),
    .irq_q(irq_q), .chg(chg_evt));

  assign irq_n = ~irq_q;

  // R7
  no_status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && reg_addr == '0) |=> $stable(ctrl_q));
  // R9
  bpv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_evt && !clr_evt && $stable(lst_s)) |=> $stable(irq_n));
endmodule

// File: tb/test_ctl_serial_port.sv
module test_ctl_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
  logic [3:0] line_stat = 4'h0, line_bpv = 4'h0;
  logic sdo, sdo_oe, irq_n;

  int checks = 0, errors = 0;
  bit clr_req = 0, done = 0, exp_irq = 0, c1 = 0, c2 = 0;
  logic [3:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_serial_port i_ctl_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
    .line_stat(line_stat), .line_bpv(line_bpv),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n));

  // behavioural interrupt model: input history and clear-request delay line
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      exp_irq = 0; c1 = 0; c2 = 0;
    end else begin
      if (hist[1] != hist[2]) exp_irq = 1;      // R8 / R11: change wins
      else if (c2)            exp_irq = 0;      // R10
      c2 = c1; c1 = clr_req; clr_req = 0;
      hist.push_front(line_stat);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_n !== !exp_irq) begin
        errors++;
        $display("FAIL R8/R10/R11 irq_n per-cycle: got %0b expected %0b at %0t",
                 irq_n, !exp_irq, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                      input bit chg_en, input logic [3:0] chg_val,
                      output logic [7:0] rd, output logic oe_all);
    @(negedge clk) sel_n = 1'b0;
    repeat (4) @(negedge clk);
    rd = '0; oe_all = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? cmd[7-i] : (i < 16) ? wd[15-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rd[15-i] = sdo;
        oe_all &= sdo_oe;
      end
      sclk = 1'b1;
      if (i == 7) begin
        if (cmd == 8'h80) clr_req = 1;
        if (chg_en) line_stat = chg_val;
      end
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int nbits);
    logic [7:0] r; logic o;
    xfer({6'b0, a}, d, nbits, 0, 4'h0, r, o);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic o);
    xfer({1'b1, 5'b0, a}, 8'h00, 16, 0, 4'h0, d, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d; logic o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sdo", sdo, 0);
    for (int a = 1; a < 4; a++) begin
      rd(a[1:0], d, o);
      chk("R1 ctrl reset", d, 8'h00);
    end
    // R3 R4 R5 write then read back each register
    wr(2'd1, 8'hA5, 16); wr(2'd2, 8'h3C, 16); wr(2'd3, 8'hF0, 16);
    chk("R2 oe after write", sdo_oe, 0);
    rd(2'd1, d, o); chk("R4 ctrl1", d, 8'hA5); chk("R5 oe during read", o, 1);
    rd(2'd2, d, o); chk("R3 ctrl2", d, 8'h3C);
    rd(2'd3, d, o); chk("R5 ctrl3", d, 8'hF0);
    chk("R5 oe released", sdo_oe, 0);
    // R6 status layout, also R8 and R10
    line_stat = 4'b0101; line_bpv = 4'b1010;
    repeat (10) @(negedge clk);
    chk("R8 irq set", irq_n, 0);
    rd(2'd2, d, o);
    chk("R10 ctrl read keeps irq", irq_n, 0);
    rd(2'd0, d, o);
    chk("R6 status byte", d, 8'hA5);
    chk("R10 status read clears", irq_n, 1);
    // R9 violation bits only
    line_bpv = 4'b0011;
    repeat (20) @(negedge clk);
    chk("R9 bpv no irq", irq_n, 1);
    // R8 single line change, held
    line_stat = 4'b1101;
    repeat (30) @(negedge clk);
    chk("R8 irq held", irq_n, 0);
    rd(2'd0, d, o);
    chk("R6 status after change", d, 8'h3D);
    chk("R10 cleared again", irq_n, 1);
    // R7 write to status address
    wr(2'd0, 8'hFF, 16);
    rd(2'd1, d, o); chk("R7 ctrl1 untouched", d, 8'hA5);
    rd(2'd3, d, o); chk("R7 ctrl3 untouched", d, 8'hF0);
    // R2 edges with select high
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      chk("R2 oe idle", sdo_oe, 0);
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    rd(2'd1, d, o); chk("R2 ctrl1 after idle edges", d, 8'hA5);
    // R12 over-long frame and abandoned frame
    wr(2'd1, 8'h5A, 20);
    rd(2'd1, d, o); chk("R12 long frame", d, 8'h5A);
    wr(2'd2, 8'h99, 12);
    rd(2'd2, d, o); chk("R12 aborted frame", d, 8'h3C);
    // R11 change coinciding with clearing read
    xfer(8'h80, 8'h00, 16, 1, 4'b1111, d, o);
    chk("R11 set beats clear", irq_n, 0);
    rd(2'd0, d, o);
    chk("R11 later clear", irq_n, 1);
    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule